// File: doc/BRIEF.md
# Sixteen-bit ALU with Overflow Register

This block performs the basic two-operand arithmetic and logic operations of a small 16-bit processor. A 4-bit opcode picks the operation. The block receives the two operand values, a (the destination) and b (the source). It produces the value to write back into a, and it keeps a separate overflow word, called O, whose contents depend on the operation. For each operation it also reports how many processor cycles that operation costs.

Everything is registered one stage deep. The operation presented in one clock cycle shows up on the outputs after the next rising edge. The O register sits inside the block. It is loaded only by the operations that define an O value. Every other operation leaves it exactly as it was, and the write-enable output pulses in the cycle where O takes a new value. Divide and modulo by zero have defined results. Shift amounts of any size are legal. The word width is a parameter and defaults to 16.

Top module: `alu16_ovf_core`

## Requirements
- R1: Opcode 1 (copy) makes the result equal to b, leaves O unchanged, and reports a cost of 1.
- R2: Opcode 2 (add) makes the result (a+b) mod 2^W. It loads O with 1 when the sum carries out of W bits and with 0 otherwise.
- R3: Opcode 3 (subtract) makes the result (a-b) mod 2^W. It loads O with all ones when b>a and with 0 otherwise.
- R4: Opcode 4 (multiply) makes the result the low W bits of the 2W-bit product. It loads O with the high W bits of that product.
- R5: Opcode 5 (divide) makes the result floor(a/b). It loads O with the low W bits of floor(a·2^W / b), computed from the original a. When b is 0, both the result and O are 0.
- R6: Opcode 6 (modulo) makes the result a mod b, or 0 when b is 0, and leaves O unchanged.
- R7: Opcode 7 (shift left) forms a·2^b in 2W bits. The result is its low half and O is its high half. Any b of 2W or more gives 0 for both.
- R8: Opcode 8 (shift right) forms (a·2^W)>>b in 2W bits. The result is its high half (a>>b) and O is its low half. Any b of 2W or more gives 0 for both.
- R9: Opcodes 9 (and), 0xA (or) and 0xB (exclusive-or) produce the bitwise result and leave O unchanged.
- R10: Opcodes 0 and 0xC to 0xF pass a through unchanged, leave O unchanged, and report a cost of 0.
- R11: The reported cost is 1 for copy, and, or and exclusive-or. It is 2 for add, subtract, multiply and both shifts, and 3 for divide and modulo.
- R12: The outputs change one rising edge after the inputs. The O write-enable is high exactly when the operation loads O (opcodes 2, 3, 4, 5, 7 and 8). A synchronous active-low reset clears the result, O, the write-enable and the cost to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | W | Operand a (destination value) |
| b_i | input | W | Operand b (source value) |
| res_o | output | W | Value to write back into a |
| ovf_o | output | W | Current contents of the O register |
| ovf_we_o | output | 1 | High for one cycle when O was loaded |
| cost_o | output | 2 | Cycle cost of the operation |

## Verification
The assertions assume two things about the inputs: the operands are known (never X) in every cycle after reset, and the opcode is sampled at every rising edge with no valid qualifier. Checks that compare an output with the previous cycle's input are therefore meaningful in every cycle. The stimulus drives every opcode, including the unused ones, on every cycle away from the clock edge, so it never leaves these bounds. A narrow 4-bit instance is swept over all opcode and operand combinations, covering shift amounts beyond 2W and zero divisors. The full-width instance gets directed corner cases.

// File: rtl/alu16_pkg.sv
// Shared opcode encoding and cost table for the overflow ALU.
// Assumes a 4-bit opcode field; codes not listed are treated as no-operation.
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_NOP = 4'h0,
        OP_CPY = 4'h1,
        OP_ADD = 4'h2,
        OP_SUB = 4'h3,
        OP_MUL = 4'h4,
        OP_DIV = 4'h5,
        OP_MOD = 4'h6,
        OP_SHL = 4'h7,
        OP_SHR = 4'h8,
        OP_AND = 4'h9,
        OP_IOR = 4'hA,
        OP_XOR = 4'hB
    } alu_op_e;

    // Cycle cost for an opcode (0 for unused codes).
    function automatic logic [1:0] cost_of(input logic [3:0] op);
        case (op)
            OP_CPY, OP_AND, OP_IOR, OP_XOR:         cost_of = 2'd1;
            OP_ADD, OP_SUB, OP_MUL, OP_SHL, OP_SHR: cost_of = 2'd2;
            OP_DIV, OP_MOD:                         cost_of = 2'd3;
            default:                                cost_of = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/alu_arith.sv
// Add, subtract and multiply with their overflow words.
// Purely combinational; assumes unsigned W-bit operands.
module alu_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] add_res,
    output logic [W-1:0] add_ovf,
    output logic [W-1:0] sub_res,
    output logic [W-1:0] sub_ovf,
    output logic [W-1:0] mul_res,
    output logic [W-1:0] mul_ovf
);
    localparam int WW = 2 * W;

    logic [W:0]    sum;
    logic [W:0]    diff;
    logic [WW-1:0] prod;

    // Form the wide sum, difference and product, then split them.
    always_comb begin
        sum     = {1'b0, a} + {1'b0, b};
        diff    = {1'b0, a} - {1'b0, b};
        prod    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        add_res = sum[W-1:0];
        add_ovf = {{(W-1){1'b0}}, sum[W]};
        sub_res = diff[W-1:0];
        sub_ovf = {W{diff[W]}};
        mul_res = prod[W-1:0];
        mul_ovf = prod[WW-1:W];
    end
endmodule

// File: rtl/alu_divmod.sv
// Divide (with fractional overflow word) and modulo; zero divisor yields zeros.
// Purely combinational; the fraction uses the original dividend.
module alu_divmod #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] div_res,
    output logic [W-1:0] div_ovf,
    output logic [W-1:0] mod_res
);
    localparam int WW = 2 * W;

    logic [WW-1:0] frac_q;
    logic          zero_div;

    // Quotient, scaled quotient and remainder, guarded against b == 0.
    always_comb begin
        zero_div = (b == '0);
        frac_q   = '0;
        div_res  = '0;
        div_ovf  = '0;
        mod_res  = '0;
        if (!zero_div) begin
            frac_q  = {a, {W{1'b0}}} / {{W{1'b0}}, b};
            div_res = a / b;
            div_ovf = frac_q[W-1:0];
            mod_res = a % b;
        end
    end
endmodule

// File: rtl/alu_shift.sv
// Left and right logical shifts through a double-width window; the part
// shifted out of the word becomes the overflow word. Any shift amount is legal.
module alu_shift #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] shl_res,
    output logic [W-1:0] shl_ovf,
    output logic [W-1:0] shr_res,
    output logic [W-1:0] shr_ovf
);
    localparam int WW = 2 * W;

    logic [WW-1:0] lwin;
    logic [WW-1:0] rwin;

    // Shift a zero-extended / zero-appended copy of a, then split halves.
    always_comb begin
        lwin    = {{W{1'b0}}, a} << b;
        rwin    = {a, {W{1'b0}}} >> b;
        shl_res = lwin[W-1:0];
        shl_ovf = lwin[WW-1:W];
        shr_res = rwin[WW-1:W];
        shr_ovf = rwin[W-1:0];
    end
endmodule

// File: rtl/alu16_ovf_core.sv
// Registered two-operand ALU with an internal overflow (O) register.
// Selects one operation per cycle from op_i; results appear after one edge.
// Assumes operands are known every cycle after reset; no valid qualifier.
module alu16_ovf_core
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic [W-1:0] ovf_o,
    output logic         ovf_we_o,
    output logic [1:0]   cost_o
);
    logic [W-1:0] add_r, add_v, sub_r, sub_v, mul_r, mul_v;
    logic [W-1:0] div_r, div_v, mod_r;
    logic [W-1:0] shl_r, shl_v, shr_r, shr_v;

    logic [W-1:0] nxt_res;
    logic [W-1:0] nxt_ovf;
    logic         nxt_we;

    logic [W-1:0] res_q;
    logic [W-1:0] ovf_q;
    logic         we_q;
    logic [1:0]   cost_q;

    alu_arith #(.W(W)) u_arith (
        .a(a_i), .b(b_i),
        .add_res(add_r), .add_ovf(add_v),
        .sub_res(sub_r), .sub_ovf(sub_v),
        .mul_res(mul_r), .mul_ovf(mul_v)
    );

    alu_divmod #(.W(W)) u_divmod (
        .a(a_i), .b(b_i),
        .div_res(div_r), .div_ovf(div_v), .mod_res(mod_r)
    );

    alu_shift #(.W(W)) u_shift (
        .a(a_i), .b(b_i),
        .shl_res(shl_r), .shl_ovf(shl_v),
        .shr_res(shr_r), .shr_ovf(shr_v)
    );

    // Pick the result, O value and O write-enable for the current opcode.
    always_comb begin
        nxt_res = a_i;
        nxt_ovf = '0;
        nxt_we  = 1'b0;
        case (op_i)
            OP_CPY: nxt_res = b_i;
            OP_ADD: begin nxt_res = add_r; nxt_ovf = add_v; nxt_we = 1'b1; end
            OP_SUB: begin nxt_res = sub_r; nxt_ovf = sub_v; nxt_we = 1'b1; end
            OP_MUL: begin nxt_res = mul_r; nxt_ovf = mul_v; nxt_we = 1'b1; end
            OP_DIV: begin nxt_res = div_r; nxt_ovf = div_v; nxt_we = 1'b1; end
            OP_MOD: nxt_res = mod_r;
            OP_SHL: begin nxt_res = shl_r; nxt_ovf = shl_v; nxt_we = 1'b1; end
            OP_SHR: begin nxt_res = shr_r; nxt_ovf = shr_v; nxt_we = 1'b1; end
            OP_AND: nxt_res = a_i & b_i;
            OP_IOR: nxt_res = a_i | b_i;
            OP_XOR: nxt_res = a_i ^ b_i;
            default: nxt_res = a_i;
        endcase
    end

    // Output stage and O register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            ovf_q  <= '0;
            we_q   <= 1'b0;
            cost_q <= 2'd0;
        end else begin
            res_q  <= nxt_res;
            we_q   <= nxt_we;
            cost_q <= cost_of(op_i);
            if (nxt_we) begin
                ovf_q <= nxt_ovf;
            end
        end
    end

    assign res_o    = res_q;
    assign ovf_o    = ovf_q;
    assign ovf_we_o = we_q;
    assign cost_o   = cost_q;

    // R1: copy returns b one edge later
    a_r1_copy_b: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CPY) |=> (res_o == $past(b_i)));

    // R2: add loads O with 0 or 1 only
    a_r2_add_carry_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD) |=> (ovf_o == '0 || ovf_o == W'(1)));

    // R3: subtract loads O with all zeros or all ones
    a_r3_sub_borrow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SUB) |=> (ovf_o == '0 || ovf_o == '1));

    // R5: zero divisor clears both result and O
    a_r5_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DIV && b_i == '0) |=> (res_o == '0 && ovf_o == '0));

    // R6: modulo leaves O alone
    a_r6_mod_keeps_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_MOD) |=> ($stable(ovf_o) && !ovf_we_o));

    // R9: bitwise operations never load O
    a_r9_logic_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_AND || op_i == OP_IOR || op_i == OP_XOR) |=> ($stable(ovf_o) && !ovf_we_o));

    // R10: unused opcodes pass a and cost nothing
    a_r10_unused_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'h0 || op_i >= 4'hC) |=> (res_o == $past(a_i) && cost_o == 2'd0 && !ovf_we_o));

    // R12: O only moves when the write-enable reports a load
    a_r12_ovf_moves_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_we_o |-> (ovf_o == $past(ovf_o)));
endmodule

// File: tb/alu16_ovf_core_tb.sv
`timescale 1ns/1ps
module alu16_ovf_core_tb;
    localparam int NW = 4;
    localparam int FW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [3:0]    op_n = '0, op_f = '0;
    logic [NW-1:0] a_n = '0, b_n = '0;
    logic [FW-1:0] a_f = '0, b_f = '0;
    logic [NW-1:0] res_n, ovf_n;
    logic [FW-1:0] res_f, ovf_f;
    logic          we_n, we_f;
    logic [1:0]    cost_n, cost_f;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    longint o_model_n = 0;
    longint o_model_f = 0;

    alu16_ovf_core #(.W(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_n), .a_i(a_n), .b_i(b_n),
        .res_o(res_n), .ovf_o(ovf_n), .ovf_we_o(we_n), .cost_o(cost_n)
    );

    alu16_ovf_core #(.W(FW)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .op_i(op_f), .a_i(a_f), .b_i(b_f),
        .res_o(res_f), .ovf_o(ovf_f), .ovf_we_o(we_f), .cost_o(cost_f)
    );

    // Arithmetic reference from the requirements.
    task automatic model(input int w, input int op, input longint a, input longint b,
                         input longint o_prev, output longint r, output longint o,
                         output bit we, output int cost, output string tag);
        longint m = (64'd1 << w) - 1;
        longint t;
        r = a; o = o_prev; we = 0; cost = 0; tag = "R10";
        case (op)
            1: begin r = b; cost = 1; tag = "R1"; end
            2: begin t = a + b; r = t & m; o = (t > m) ? 1 : 0; we = 1; cost = 2; tag = "R2"; end
            3: begin r = (a - b) & m; o = (a < b) ? m : 0; we = 1; cost = 2; tag = "R3"; end
            4: begin t = a * b; r = t & m; o = (t >> w) & m; we = 1; cost = 2; tag = "R4"; end
            5: begin
                if (b == 0) begin r = 0; o = 0; end
                else begin r = a / b; o = ((a << w) / b) & m; end
                we = 1; cost = 3; tag = "R5";
            end
            6: begin r = (b == 0) ? 0 : a % b; cost = 3; tag = "R6"; end
            7: begin
                t = (b >= 2 * w) ? 0 : (a << b);
                r = t & m; o = (t >> w) & m; we = 1; cost = 2; tag = "R7";
            end
            8: begin
                t = (b >= 2 * w) ? 0 : ((a << w) >> b);
                r = (t >> w) & m; o = t & m; we = 1; cost = 2; tag = "R8";
            end
            9:  begin r = a & b; cost = 1; tag = "R9"; end
            10: begin r = a | b; cost = 1; tag = "R9"; end
            11: begin r = a ^ b; cost = 1; tag = "R9"; end
            default: ;
        endcase
    endtask

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Apply one vector to the narrow instance and check after the edge.
    task automatic run_narrow(input int op, input int a, input int b);
        longint r, o; bit we; int cost; string tag;
        model(NW, op, a, b, o_model_n, r, o, we, cost, tag);
        op_n = op[3:0]; a_n = a[NW-1:0]; b_n = b[NW-1:0];
        @(posedge clk); #1;
        check(tag, "res", res_n, r);
        check(tag, "ovf", ovf_n, o);
        check("R12", "ovf_we", we_n, we);
        check("R11", "cost", cost_n, cost);
        o_model_n = o;
    endtask

    // Apply one vector to the wide instance and check after the edge.
    task automatic run_wide(input int op, input longint a, input longint b);
        longint r, o; bit we; int cost; string tag;
        model(FW, op, a, b, o_model_f, r, o, we, cost, tag);
        op_f = op[3:0]; a_f = a[FW-1:0]; b_f = b[FW-1:0];
        @(posedge clk); #1;
        check(tag, "wide res", res_f, r);
        check(tag, "wide ovf", ovf_f, o);
        check("R12", "wide ovf_we", we_f, we);
        check("R11", "wide cost", cost_f, cost);
        o_model_f = o;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        op_n = 4'h2; a_n = '1; b_n = '1;
        op_f = 4'h2; a_f = '1; b_f = '1;
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        check("R12", "reset res", res_n, 0);
        check("R12", "reset ovf", ovf_n, 0);
        check("R12", "reset we", we_n, 0);
        check("R12", "reset cost", cost_n, 0);
        check("R12", "wide reset ovf", ovf_f, 0);
        rst_n = 1'b1;
        op_n = 4'h0; op_f = 4'h0;
        @(posedge clk); #1;

        // Exhaustive sweep of the narrow instance: every opcode, a and b.
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    run_narrow(op, a, b);
                end
            end
        end
        // R6/R9/R1: interleave an O load with non-loading ops to prove O is held.
        run_narrow(4, 15, 15);
        run_narrow(6, 9, 4);
        run_narrow(9, 7, 3);
        run_narrow(1, 2, 5);
        run_narrow(14, 3, 3);

        // Full-width directed corners.
        run_wide(2, 64'hFFFF, 1);       // R2 carry
        run_wide(2, 64'h7FFF, 1);       // R2 no carry
        run_wide(3, 0, 1);              // R3 borrow
        run_wide(3, 5, 5);              // R3 equal
        run_wide(4, 64'hFFFF, 64'hFFFF); // R4 high half
        run_wide(5, 1, 3);              // R5 fraction
        run_wide(5, 64'hFFFF, 2);       // R5 original a in fraction
        run_wide(7, 64'h8001, 1);       // R7
        run_wide(6, 10, 0);             // R6 zero divisor, O held
        run_wide(8, 3, 1);              // R8
        run_wide(10, 64'hF0F0, 64'h0F0F); // R9 O held
        run_wide(7, 64'h1234, 40);      // R7 huge shift
        run_wide(8, 64'h1234, 64'hFFFF); // R8 huge shift
        run_wide(8, 64'h8000, 31);      // R8 edge of window
        run_wide(5, 7, 0);              // R5 zero divisor
        run_wide(15, 64'hABCD, 1);      // R10 unused opcode
        finish_run();
    end
endmodule